// File: doc/BRIEF.md
# Shared-Pin GPIO Port with Peripheral Direction Overrides

This block drives an eight-pin general-purpose port. Software configures it through a small register bus. There are three stored registers: pin direction, output data and reduced drive. A fourth, read-only register returns the pin levels. The lower four pins are shared with on-chip serial and PWM peripherals. For each of those pins a fixed priority chain of peripheral requests can overrule the software direction bit. A request forces the pin either to output or to input. When a peripheral forces a pin to output, that peripheral also supplies the pad value. The upper four pins follow the software registers only.

Pad input levels pass through a two-flop synchronizer before they can be read. This means a read can trail a direction change or a pin change by up to two clock cycles. The effective direction, the pad output value and the reduced-drive bit of every pin leave the block as plain per-pin signals for the pad model.

The register bus is a plain single-cycle access port with no back-pressure. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` and is valid in the same cycle. No data stream enters or leaves the block, so there is no valid/ready handshake.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset, the direction, data and reduced-drive registers hold 0, every `pad_oe` bit is 0 while no peripheral is enabled, and `pad_rdrv` is 0.
- R2: The direction register is at address 2 and is read and written at any time. With no override, bit n = 1 makes pin n an output (`pad_oe[n]`=1) and 0 makes it an input. Pins 7..4 are never overridden.
- R3: While `can_en`=1, pin 3 is an output driving `can_tx` and pin 2 is an input, regardless of the direction register.
- R4: While `sci_en`=1, pin 1 is an output driving `sci_tx` and pin 0 is an input. This takes priority over both PWM routings.
- R5: With `sci_en`=0 and `pwm7_route`=1, pin 1 follows the PWM7 mode. When `pwm7_sd`=0 it is an output driving `pwm7_out`. When `pwm7_sd`=1 it is an input.
- R6: With `sci_en`=0, pin 0 is an output driving `pwm6_out` when `pwm6_route`=1 and `pwm6_en`=1. If either of the two is 0, pin 0 follows the direction register.
- R7: A pin that is an output and is not forced by a peripheral drives its bit of the data register (address 0) on `pad_out`.
- R8: Reading address 1 returns the level of `pad_in` sampled at the second-to-last rising clock edge. This is a two-flop synchronizer.
- R9: Reading address 0 returns, per pin, the data register bit where the effective direction is output and the synchronized pin level where it is input.
- R10: The reduced-drive register is at address 3. It holds 8 bits, is read and written at any time, and drives `pad_rdrv`.
- R11: A write to address 1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 2 | 0 data, 1 level, 2 direction, 3 reduced drive |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| can_en | input | 1 | CAN controller enable |
| can_tx | input | 1 | CAN transmit value for pin 3 |
| sci_en | input | 1 | Serial interface enable |
| sci_tx | input | 1 | Serial transmit value for pin 1 |
| pwm7_route | input | 1 | PWM channel 7 routed to pin 1 |
| pwm7_sd | input | 1 | PWM7 pin used as shutdown input (1) or channel output (0) |
| pwm7_out | input | 1 | PWM channel 7 output value |
| pwm6_route | input | 1 | PWM channel 6 routed to pin 0 |
| pwm6_en | input | 1 | PWM channel 6 enable |
| pwm6_out | input | 1 | PWM channel 6 output value |
| pad_in | input | 8 | Pin input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Effective direction, 1 = output |
| pad_rdrv | output | 8 | Reduced-drive select per pin |

## Verification
A behavioural model is compared with the design on every clock. The stimulus randomizes bus accesses, peripheral enables, routing bits and pin levels. Because every override input toggles on its own, each priority chain meets all of its combinations. SCI against PWM7, and SCI against PWM6, show whether the priority order is right. PWM6 routed with the channel disabled separates the two-condition gate from a single-condition one. Pin levels change at random while the level and data registers are read, which exposes a synchronizer that is one stage short or one stage long. Directed steps check the reset state and the write to the read-only address.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 2'd0,
    REG_LEVEL = 2'd1,
    REG_DIR   = 2'd2,
    REG_DRIVE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = PORT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         dir_q,
  output logic [W-1:0]         dat_q,
  output logic [W-1:0]         drv_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      drv_q <= '0;
    end else if (wr_en) begin
      case (reg_sel_e'(addr))
        REG_DATA:  dat_q <= wdata;
        REG_DIR:   dir_q <= wdata;
        REG_DRIVE: drv_q <= wdata;
        default:   ;
      endcase
    end
  end

  a_r11_level_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_LEVEL) |=> ($stable(dir_q) && $stable(dat_q) && $stable(drv_q)));

  a_r10_drive_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_DRIVE) |=> (drv_q == $past(wdata)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  if (STAGES == 2) begin : g_chk
    a_r8_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 2'd2) |-> (q == $past(d, 2)));
  end
endmodule

// File: rtl/gpio_override.sv
module gpio_override #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sw_dir,
  input  logic [W-1:0] sw_dat,
  input  logic         can_en,
  input  logic         can_tx,
  input  logic         sci_en,
  input  logic         sci_tx,
  input  logic         pwm7_route,
  input  logic         pwm7_sd,
  input  logic         pwm7_out,
  input  logic         pwm6_route,
  input  logic         pwm6_en,
  input  logic         pwm6_out,
  output logic [W-1:0] oe,
  output logic [W-1:0] out
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    if (p == 3) begin : g_can_tx
      assign oe[p]  = can_en | sw_dir[p];
      assign out[p] = can_en ? can_tx : sw_dat[p];
    end else if (p == 2) begin : g_can_rx
      assign oe[p]  = ~can_en & sw_dir[p];
      assign out[p] = sw_dat[p];
    end else if (p == 1) begin : g_sci_tx
      logic pwm_drive;
      always_comb begin
        pwm_drive = 1'b0;
        if (sci_en) begin
          oe[p]  = 1'b1;
          out[p] = sci_tx;
        end else if (pwm7_route) begin
          oe[p]     = ~pwm7_sd;
          pwm_drive = ~pwm7_sd;
          out[p]    = pwm7_out;
        end else begin
          oe[p]  = sw_dir[p];
          out[p] = sw_dat[p];
        end
      end
    end else if (p == 0) begin : g_sci_rx
      always_comb begin
        if (sci_en) begin
          oe[p]  = 1'b0;
          out[p] = sw_dat[p];
        end else if (pwm6_route && pwm6_en) begin
          oe[p]  = 1'b1;
          out[p] = pwm6_out;
        end else begin
          oe[p]  = sw_dir[p];
          out[p] = sw_dat[p];
        end
      end
    end else begin : g_plain
      assign oe[p]  = sw_dir[p];
      assign out[p] = sw_dat[p];
    end
  end

  a_r3_can_pins: assert property (@(posedge clk) disable iff (!rst_n)
    can_en |-> (oe[3] && !oe[2] && out[3] == can_tx));
  a_r4_sci_pins: assert property (@(posedge clk) disable iff (!rst_n)
    sci_en |-> (oe[1] && !oe[0] && out[1] == sci_tx));
  a_r5_pwm7_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_en && pwm7_route && pwm7_sd) |-> !oe[1]);
  a_r6_pwm6_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!sci_en && pwm6_route && pwm6_en) |-> (oe[0] && out[0] == pwm6_out));
  a_r2_upper_software: assert property (@(posedge clk) disable iff (!rst_n)
    oe[W-1:4] == sw_dir[W-1:4]);
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic              can_en,
  input  logic              can_tx,
  input  logic              sci_en,
  input  logic              sci_tx,
  input  logic              pwm7_route,
  input  logic              pwm7_sd,
  input  logic              pwm7_out,
  input  logic              pwm6_route,
  input  logic              pwm6_en,
  input  logic              pwm6_out,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic [PORT_W-1:0] pad_rdrv
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [PORT_W-1:0] dir_q, dat_q, drv_q, level_s;

  gpio_regs #(.W(PORT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_sel & bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .dir_q(dir_q), .dat_q(dat_q), .drv_q(drv_q)
  );

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(level_s)
  );

  gpio_override #(.W(PORT_W)) u_ovr (
    .clk(clk), .rst_n(rst_n), .sw_dir(dir_q), .sw_dat(dat_q),
    .can_en(can_en), .can_tx(can_tx), .sci_en(sci_en), .sci_tx(sci_tx),
    .pwm7_route(pwm7_route), .pwm7_sd(pwm7_sd), .pwm7_out(pwm7_out),
    .pwm6_route(pwm6_route), .pwm6_en(pwm6_en), .pwm6_out(pwm6_out),
    .oe(pad_oe), .out(pad_out)
  );

  assign pad_rdrv = drv_q;

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_DATA:  bus_rdata = (pad_oe & dat_q) | (~pad_oe & level_s);
      REG_LEVEL: bus_rdata = level_s;
      REG_DIR:   bus_rdata = dir_q;
      default:   bus_rdata = drv_q;
    endcase
  end

  a_r9_data_read_mix: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == REG_DATA) |-> ((bus_rdata & ~pad_oe) == (level_s & ~pad_oe)));
endmodule

// File: tb/tb_gpio_port_mux.sv
module tb_gpio_port_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic can_en = 0, can_tx = 0, sci_en = 0, sci_tx = 0;
  logic pwm7_route = 0, pwm7_sd = 0, pwm7_out = 0;
  logic pwm6_route = 0, pwm6_en = 0, pwm6_out = 0;
  logic [7:0] pad_in = 0;
  logic [7:0] pad_out, pad_oe, pad_rdrv;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port_mux dut (.*);

  // behavioural reference state
  logic [7:0] m_dir, m_dat, m_drv;
  logic [7:0] m_hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = 0; m_dat = 0; m_drv = 0;
      m_hist = {8'h00, 8'h00};
    end else begin
      m_hist.push_back(pad_in);
      void'(m_hist.pop_front());
      if (bus_sel && bus_wr) begin
        if (bus_addr == 2'd0) m_dat = bus_wdata;
        if (bus_addr == 2'd2) m_dir = bus_wdata;
        if (bus_addr == 2'd3) m_drv = bus_wdata;
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [7:0] level, eoe, eout, rd;
    string tg;
    level = m_hist[0];
    for (int p = 0; p < 8; p++) begin
      eoe[p] = m_dir[p];
      eout[p] = m_dat[p];
      tg = (p < 4) ? "R7" : "R2";
      if (p == 3 && can_en) begin eoe[p] = 1; eout[p] = can_tx; tg = "R3"; end
      if (p == 2 && can_en) begin eoe[p] = 0; tg = "R3"; end
      if (p == 1) begin
        if (sci_en) begin eoe[p] = 1; eout[p] = sci_tx; tg = "R4"; end
        else if (pwm7_route) begin eoe[p] = !pwm7_sd; eout[p] = pwm7_out; tg = "R5"; end
      end
      if (p == 0) begin
        if (sci_en) begin eoe[p] = 0; tg = "R4"; end
        else if (pwm6_route && pwm6_en) begin eoe[p] = 1; eout[p] = pwm6_out; tg = "R6"; end
        else if (pwm6_route) tg = "R6";
      end
      check({tg, " oe"}, {7'd0, pad_oe[p]}, {7'd0, eoe[p]});
      if (eoe[p]) check({tg, " out"}, {7'd0, pad_out[p]}, {7'd0, eout[p]});
    end
    check("R10 rdrv", pad_rdrv, m_drv);
    case (bus_addr)
      2'd0: begin
        for (int p = 0; p < 8; p++) rd[p] = eoe[p] ? m_dat[p] : level[p];
        check("R9 data read", bus_rdata, rd);
      end
      2'd1: check("R8 level read", bus_rdata, level);
      2'd2: check("R2 dir read", bus_rdata, m_dir);
      default: check("R10 drive read", bus_rdata, m_drv);
    endcase
  endtask

  task automatic randomize_inputs(input int phase);
    bus_sel = ($urandom % 3) != 0;
    bus_wr = $urandom % 2;
    bus_addr = $urandom % 4;
    bus_wdata = $urandom;
    can_en = (phase == 1) ? 1'b1 : ($urandom % 3 == 0);
    sci_en = (phase == 2) ? 1'b0 : ($urandom % 3 == 0);
    can_tx = $urandom; sci_tx = $urandom;
    pwm7_route = $urandom; pwm7_sd = $urandom; pwm7_out = $urandom;
    pwm6_route = $urandom; pwm6_en = $urandom; pwm6_out = $urandom;
    if ($urandom % 2) pad_in = $urandom;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    bus_addr = 2'd2; #0;
    check("R1 dir reset", bus_rdata, 8'h00);
    check("R1 oe reset", pad_oe, 8'h00);
    check("R1 rdrv reset", pad_rdrv, 8'h00);
    bus_addr = 2'd0; #1;
    check("R1 data reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    // R11: write to level address, then read registers back
    bus_sel = 1; bus_wr = 1; bus_addr = 2'd1; bus_wdata = 8'hFF;
    @(negedge clk);
    bus_wr = 0; bus_addr = 2'd2; #1;
    check("R11 dir after level write", bus_rdata, 8'h00);
    bus_addr = 2'd3; #1;
    check("R11 drive after level write", bus_rdata, 8'h00);
    check("R11 oe after level write", pad_oe, 8'h00);
    for (int ph = 0; ph < 3; ph++) begin
      for (int c = 0; c < 1500; c++) begin
        @(negedge clk);
        compare_all();
        randomize_inputs(ph);
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule